// File: doc/BRIEF.md
# Time-over-threshold hit digitizer

This block sits behind the per-strip discriminators of a silicon strip readout chip. On every sample tick it looks at each channel's discriminator level and times how many ticks each pulse stays high. When a pulse ends, the block stores a hit record in that channel's small pending store. The record holds a 5-bit timestamp, taken from the free-running tick counter at the first high sample, and a 4-bit code that grows with the logarithm of the pulse length.

A trigger arrives a fixed latency after the interaction it belongs to. When it comes, each channel looks for one pending hit whose age matches the programmed latency to within one tick. Hits that are too old for any later trigger are dropped. Only the channels that found a match take part in readout. They are sent in ascending channel order, one record per accepted handshake cycle, and the final record carries a last marker. Each record carries the channel number, the timestamp and the code.

Top module: `tot_hit_digitizer`

## Requirements
- R1: After reset, rd_valid_o, rd_last_o and every ovf_o bit are 0, and the tick counter is 0.
- R2: A pulse seen high on d consecutive tick samples gets the code floor(log2 d)+1, limited to 15. So 1 tick gives 1, 2 to 3 ticks give 2, 4 to 7 ticks give 3, 8 to 15 ticks give 4, and 16384 ticks or more give 15.
- R3: The timestamp of a hit is the 5-bit tick counter value (it wraps modulo 32) at the tick that first samples the level high. The record is stored at the tick that first samples it low again.
- R4: The discriminator input is sampled only in cycles where tick_i is 1. A pulse that begins and ends while tick_i is 0 leaves no hit.
- R5: On an accepted trigger, a pending hit is selected when its age, (counter − timestamp) mod 32, lies in lat_i−1 .. lat_i+1, with lat_i in 1..30. At most one hit per channel is selected per trigger, the one in the lowest store slot.
- R6: On an accepted trigger, pending hits whose age exceeds lat_i+1 are discarded. Hits younger than lat_i−1 are kept for later triggers.
- R7: Each channel holds at most 4 pending hits. A hit that ends while all 4 are taken is dropped and sets that channel's ovf_o bit, which stays set until reset.
- R8: Readout is sparse. Only channels with a selected hit emit a record, in ascending channel order, and rd_chan_o is the channel index as a 7-bit number.
- R9: While rd_valid_o is 1 and rd_ready_i is 0, all read outputs hold their values. rd_last_o is 1 only on the final record of a trigger.
- R10: A trigger that arrives while records are still pending is ignored. A trigger that matches no hit produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample strobe; the counter and the discriminator sampling advance only on it |
| disc_i | input | NCH | Discriminator levels, one per channel |
| lat_i | input | 5 | Trigger latency in ticks, 1..30 |
| trig_i | input | 1 | Trigger pulse, one cycle |
| rd_ready_i | input | 1 | Downstream accepts the current record |
| rd_valid_o | output | 1 | A record is offered |
| rd_chan_o | output | 7 | Channel number of the record |
| rd_ts_o | output | 5 | Hit timestamp |
| rd_tot_o | output | 4 | Logarithmic pulse-length code |
| rd_last_o | output | 1 | Final record of this trigger |
| ovf_o | output | NCH | Sticky per-channel store overflow |

## Verification
A hit becomes pending at the clock edge that samples the discriminator low, so the bench only starts the age count one cycle after it drops its input. A trigger driven before edge E is judged with the counter value that the bench's own tick model holds at that moment, and its first record is due right after E. Each later record is due one edge after the previous one was accepted with ready high. All outputs are read on the falling clock edge, half a cycle after the edge that updates them. The discard and drop behaviour is checked by triggering again exactly when the lost hit would have matched and expecting no record.

// File: rtl/tot_pkg.sv
package tot_pkg;
  localparam int TS_W  = 5;
  localparam int TOT_W = 4;
  localparam int CH_W  = 7;

  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [TOT_W-1:0] tot;
  } hit_rec_t;

  // floor(log2 d)+1, saturated at the top code
  function automatic logic [TOT_W-1:0] tot_code(input logic [31:0] dur);
    int msb;
    msb = 0;
    for (int i = 0; i < 32; i++) if (dur[i]) msb = i + 1;
    if (msb > (1 << TOT_W) - 1) msb = (1 << TOT_W) - 1;
    return TOT_W'(msb);
  endfunction
endpackage

// File: rtl/tot_channel.sv
module tot_channel
  import tot_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DUR_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            disc_i,
  input  logic [TS_W-1:0] now_i,
  input  logic [TS_W-1:0] lat_i,
  input  logic            trig_i,
  input  logic            pop_i,
  output logic            sel_valid_o,
  output hit_rec_t        rec_o,
  output logic            ovf_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  logic             disc_q;
  logic [TS_W-1:0]  cap_ts_q;
  logic [DUR_W-1:0] dur_q;
  logic [DEPTH-1:0] slot_v_q;
  hit_rec_t         slot_q [DEPTH];
  logic             sel_v_q;
  logic [IDX_W-1:0] sel_idx_q;
  logic             ovf_q;

  logic rise, fall, hold;
  logic free_ok, hit_ok;
  logic [IDX_W-1:0] free_idx, hit_idx;
  logic [DEPTH-1:0] match, stale;
  logic [TS_W:0] lat_w;

  assign lat_w = {1'b0, lat_i};

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [TS_W-1:0] age;
    logic [TS_W:0]   age_w;
    assign age      = now_i - slot_q[g].ts;
    assign age_w    = {1'b0, age};
    assign match[g] = slot_v_q[g] && (age_w + 1'b1 >= lat_w) && (age_w <= lat_w + 1'b1);
    assign stale[g] = slot_v_q[g] && (age_w > lat_w + 1'b1);
  end

  always_comb begin
    rise     = tick_i & disc_i & ~disc_q;
    fall     = tick_i & ~disc_i & disc_q;
    hold     = tick_i & disc_i & disc_q;
    free_ok  = 1'b0;
    free_idx = '0;
    hit_ok   = 1'b0;
    hit_idx  = '0;
    // descending scan: lowest slot wins
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_v_q[i]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (match[i]) begin
        hit_ok  = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disc_q    <= 1'b0;
      cap_ts_q  <= '0;
      dur_q     <= '0;
      slot_v_q  <= '0;
      sel_v_q   <= 1'b0;
      sel_idx_q <= '0;
      ovf_q     <= 1'b0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      if (tick_i) disc_q <= disc_i;
      if (rise) begin
        cap_ts_q <= now_i;
        dur_q    <= DUR_W'(1);
      end else if (hold && dur_q != DUR_MAX) begin
        dur_q <= dur_q + 1'b1;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (trig_i && stale[i]) slot_v_q[i] <= 1'b0;
        if (pop_i && sel_v_q && sel_idx_q == IDX_W'(i)) slot_v_q[i] <= 1'b0;
        if (fall && free_ok && free_idx == IDX_W'(i)) begin
          slot_v_q[i] <= 1'b1;
          slot_q[i]   <= '{ts: cap_ts_q, tot: tot_code(32'(dur_q))};
        end
      end
      if (fall && !free_ok) ovf_q <= 1'b1;
      if (trig_i && hit_ok) begin
        sel_v_q   <= 1'b1;
        sel_idx_q <= hit_idx;
      end else if (pop_i) begin
        sel_v_q <= 1'b0;
      end
    end
  end

  assign sel_valid_o = sel_v_q;
  assign rec_o       = slot_q[sel_idx_q];
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/tot_readout.sv
module tot_readout #(
  parameter int NCH   = 4,
  parameter int CUR_W = 2
) (
  input  logic [NCH-1:0]   pend_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [CUR_W-1:0] cur_o,
  output logic             last_o,
  output logic [NCH-1:0]   pop_o
);
  logic [NCH-1:0] first;

  always_comb begin
    cur_o = '0;
    first = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        cur_o = CUR_W'(i);
        first = '0;
        first[i] = 1'b1;
      end
    end
  end

  assign valid_o = |pend_i;
  assign last_o  = valid_o && ((pend_i & ~first) == '0);
  assign pop_o   = ready_i ? first : '0;
endmodule

// File: rtl/tot_hit_digitizer.sv
module tot_hit_digitizer
  import tot_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 4,
  parameter int DUR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [NCH-1:0]   disc_i,
  input  logic [TS_W-1:0]  lat_i,
  input  logic             trig_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [CH_W-1:0]  rd_chan_o,
  output logic [TS_W-1:0]  rd_ts_o,
  output logic [TOT_W-1:0] rd_tot_o,
  output logic             rd_last_o,
  output logic [NCH-1:0]   ovf_o
);
  localparam int CUR_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [TS_W-1:0]  now_q;
  logic             trig_go;
  hit_rec_t         rec [NCH];
  logic [NCH-1:0]   pend, pop;
  logic [CUR_W-1:0] cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     now_q <= '0;
    else if (tick_i) now_q <= now_q + 1'b1;
  end

  // triggers during a readout are dropped
  assign trig_go = trig_i & ~rd_valid_o;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tot_channel #(.DEPTH(DEPTH), .DUR_W(DUR_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick_i),
      .disc_i      (disc_i[g]),
      .now_i       (now_q),
      .lat_i       (lat_i),
      .trig_i      (trig_go),
      .pop_i       (pop[g]),
      .sel_valid_o (pend[g]),
      .rec_o       (rec[g]),
      .ovf_o       (ovf_o[g])
    );
  end

  tot_readout #(.NCH(NCH), .CUR_W(CUR_W)) u_rd (
    .pend_i  (pend),
    .ready_i (rd_ready_i),
    .valid_o (rd_valid_o),
    .cur_o   (cur),
    .last_o  (rd_last_o),
    .pop_o   (pop)
  );

  assign rd_chan_o = CH_W'(cur);
  assign rd_ts_o   = rec[cur].ts;
  assign rd_tot_o  = rec[cur].tot;
endmodule

// File: rtl/tot_hit_digitizer_chk.sv
module tot_hit_digitizer_chk #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           rd_ready_i,
  input logic           rd_valid_o,
  input logic [6:0]     rd_chan_o,
  input logic [4:0]     rd_ts_o,
  input logic [3:0]     rd_tot_o,
  input logic           rd_last_o,
  input logic [NCH-1:0] ovf_o
);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_chan_o) && $stable(rd_ts_o)
                                  && $stable(rd_tot_o) && $stable(rd_last_o));

  a_r9_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  a_r8_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_ready_i && !rd_last_o |=> rd_valid_o && (rd_chan_o > $past(rd_chan_o)));

  a_r8_chan_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_chan_o < 7'(NCH));

  a_r10_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && rd_ready_i && rd_last_o |=> !rd_valid_o);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ovf_o & $past(ovf_o)) == $past(ovf_o));

  a_r2_tot_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_tot_o != 4'd0);
endmodule

bind tot_hit_digitizer tot_hit_digitizer_chk #(.NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_ready_i (rd_ready_i),
  .rd_valid_o (rd_valid_o),
  .rd_chan_o  (rd_chan_o),
  .rd_ts_o    (rd_ts_o),
  .rd_tot_o   (rd_tot_o),
  .rd_last_o  (rd_last_o),
  .ovf_o      (ovf_o)
);

// File: tb/tot_hit_digitizer_test.sv
module tot_hit_digitizer_test;
  localparam int NCH = 4;
  localparam int L   = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b1;
  logic           trig = 1'b0;
  logic           ready = 1'b1;
  logic [NCH-1:0] disc = '0;
  logic [4:0]     lat = 5'(L);
  logic           rd_valid, rd_last;
  logic [6:0]     rd_chan;
  logic [4:0]     rd_ts;
  logic [3:0]     rd_tot;
  logic [NCH-1:0] ovf;
  logic [4:0]     ts_model;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tot_hit_digitizer #(.NCH(NCH), .DEPTH(4), .DUR_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .disc_i(disc), .lat_i(lat),
    .trig_i(trig), .rd_ready_i(ready), .rd_valid_o(rd_valid), .rd_chan_o(rd_chan),
    .rd_ts_o(rd_ts), .rd_tot_o(rd_tot), .rd_last_o(rd_last), .ovf_o(ovf)
  );

  // independent tick counter from R1/R3
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ts_model <= '0;
    else if (tick) ts_model <= ts_model + 5'd1;

  function automatic int exp_code(input int d);
    int m;
    m = 0;
    for (int i = 0; i < 31; i++) if (d >= (1 << i)) m = i + 1;
    return (m > 15) ? 15 : m;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int ch, input int n, output logic [4:0] ts);
    ts = ts_model;
    disc[ch] = 1'b1;
    repeat (n) @(negedge clk);
    disc[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_age(input logic [4:0] ts, input int a);
    while (5'(ts_model - ts) != 5'(a)) @(negedge clk);
  endtask

  task automatic fire();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic expect_rec(input int ch, input logic [4:0] ts, input int tot,
                            input int last, input string tag);
    chk({tag, " valid"}, int'(rd_valid), 1);
    chk({tag, " chan"}, int'(rd_chan), ch);
    chk({tag, " ts"}, int'(rd_ts), int'(ts));
    chk({tag, " tot"}, int'(rd_tot), tot);
    chk({tag, " last"}, int'(rd_last), last);
    @(negedge clk);
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " no record"}, int'(rd_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(rd_valid), 0);
    chk("R1 last", int'(rd_last), 0);
    chk("R1 ovf", int'(ovf), 0);
  endtask

  task automatic t_codes();
    logic [4:0] ts;
    int durs [6] = '{1, 2, 3, 4, 7, 8};
    foreach (durs[k]) begin
      pulse(1, durs[k], ts);
      wait_age(ts, L);
      fire();
      expect_rec(1, ts, exp_code(durs[k]), 1, "R2 R3 code");
      expect_none("R2 after");
    end
  endtask

  task automatic t_saturate();
    logic [4:0] ts;
    pulse(1, 20000, ts);
    wait_age(ts, L);
    fire();
    expect_rec(1, ts, 15, 1, "R2 saturate");
    expect_none("R2 saturate after");
  endtask

  task automatic t_window();
    logic [4:0] ts;
    pulse(0, 1, ts);
    wait_age(ts, L - 1);
    fire();
    expect_rec(0, ts, 1, 1, "R5 age lat-1");
    pulse(0, 1, ts);
    wait_age(ts, L + 1);
    fire();
    expect_rec(0, ts, 1, 1, "R5 age lat+1");
    pulse(0, 1, ts);
    wait_age(ts, L + 2);
    fire();
    expect_none("R6 too old");
    wait_age(ts, L);
    fire();
    expect_none("R6 discarded");
    pulse(0, 1, ts);
    wait_age(ts, L - 3);
    fire();
    expect_none("R6 too young");
    wait_age(ts, L);
    fire();
    expect_rec(0, ts, 1, 1, "R6 young kept");
  endtask

  task automatic t_sparse();
    logic [4:0] ts;
    ts = ts_model;
    disc = 4'b1101;
    @(negedge clk); disc[0] = 1'b0;
    @(negedge clk); disc[2] = 1'b0;
    @(negedge clk);
    @(negedge clk); disc[3] = 1'b0;
    @(negedge clk);
    wait_age(ts, L);
    ready = 1'b0;
    fire();
    chk("R9 stall chan", int'(rd_chan), 0);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk("R9 held valid", int'(rd_valid), 1);
    chk("R9 held chan", int'(rd_chan), 0);
    chk("R9 held tot", int'(rd_tot), 1);
    ready = 1'b1;
    expect_rec(0, ts, 1, 0, "R8 first");
    expect_rec(2, ts, 2, 0, "R8 second");
    expect_rec(3, ts, 3, 1, "R8 R9 last");
    expect_none("R10 busy trigger ignored");
  endtask

  task automatic t_tick_gate();
    int seen;
    seen = 0;
    tick = 1'b0;
    disc[1] = 1'b1;
    repeat (3) @(negedge clk);
    disc[1] = 1'b0;
    @(negedge clk);
    tick = 1'b1;
    for (int k = 0; k < 34; k++) begin
      fire();
      if (rd_valid) seen++;
    end
    chk("R4 R10 gated pulse leaves no hit", seen, 0);
  endtask

  task automatic t_overflow();
    logic [4:0] ts0, ts;
    pulse(2, 1, ts0);
    for (int k = 0; k < 3; k++) pulse(2, 1, ts);
    chk("R7 four fit", int'(ovf), 0);
    pulse(2, 1, ts);
    chk("R7 fifth drops", int'(ovf), 4);
    wait_age(ts0, L);
    fire();
    expect_rec(2, ts0, 1, 1, "R7 oldest read");
    wait_age(ts0, L + 8);
    fire();
    expect_none("R7 dropped hit absent");
    chk("R7 sticky", int'(ovf), 4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 counter start", int'(ts_model), 1);
    t_codes();
    t_saturate();
    t_window();
    t_sparse();
    t_tick_gate();
    t_overflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule